// File: doc/BRIEF.md
# ADC Conversion Mode Controller

This block sits between a register interface and an analog-to-digital converter core. It holds an 8-bit configuration byte and a 16-bit result word. It also decides when the core is powered and when a conversion is requested. The core is treated as a simple handshake. The block raises a one-cycle start request together with a gain code. Some cycles later the core returns a one-cycle done strobe with a 12-bit two's-complement sample.

There are two operating modes. In continuous mode, every finished sample is stored and the next conversion is requested immediately. In single-shot mode, software arms one conversion by writing the start/busy bit. The core then runs once, stores its sample and powers down. The start/busy bit reads back as "converting" in both cases. It has different meanings on write and on read, and it must behave correctly when the mode changes while a conversion is still running.

Top module: `adc_mode_ctrl`

## Requirements
- R1: After reset (asynchronous `rst_ni` or synchronous `soft_rst_i`), the configuration reads 0x80 and the result reads 0. Continuous mode is selected, so a start pulse follows automatically.
- R2: Configuration layout: bit 7 is start/busy, bit 4 selects single-shot (1) or continuous (0), and bits 1:0 are the gain code. Bits 6, 5, 3 and 2 are forced to zero on every write and always read 0.
- R3: In continuous mode, each done strobe stores the sample, and a new start pulse follows in the next cycle. Bit 7 always reads 1, and the value written to it is ignored.
- R4: In single-shot mode with the core idle, a write with bit 7 = 1 powers the core and issues one start pulse in the next cycle. A write with bit 7 = 0 issues no start.
- R5: A write with bit 7 = 1 while a conversion is running produces no additional start pulse.
- R6: When a single-shot conversion completes, the sample is stored. In the next cycle bit 7 reads 0, core power is off, and no further start is issued.
- R7: When the mode is changed from continuous to single-shot during a conversion, that conversion runs to completion. Bit 7 reads 1 until the done strobe, after which the core powers down.
- R8: The result holds the sample right-justified, with bits 15:12 equal to the sample's sign bit.
- R9: `soft_rst_i` aborts any running conversion. It drops core power and clears the result to 0. The result stays 0 until the next done strobe.
- R10: The gain code is latched onto `core_gain_o` at each start. A gain write during a conversion takes effect only from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous reset request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write byte |
| cfg_o | output | 8 | Configuration read-back |
| result_o | output | 16 | Sign-extended result |
| core_pwr_o | output | 1 | Core power enable |
| core_start_o | output | 1 | One-cycle conversion start request |
| core_gain_o | output | 2 | Gain code latched at start |
| core_done_i | input | 1 | Core conversion-complete strobe |
| core_sample_i | input | 12 | Core sample, two's complement |

## Verification
The hardest state to reach from the ports is a switch from continuous to single-shot that lands inside a running conversion. The write must fall between a start pulse and its done strobe, and then the power-down must be observed one cycle after that strobe. The bench uses a core model with a fixed latency. It issues the mode write two cycles after an observed start pulse, so the write is known to fall mid-conversion. The same timing is used to send start writes that must be ignored, to apply gain changes that must not reach the running conversion, and to assert a synchronous reset that must abort the conversion.

// File: rtl/adc_mode_pkg.sv
package adc_mode_pkg;
  localparam int SAMPLE_W   = 12;
  localparam int RESULT_W   = 16;
  localparam int CFG_W      = 8;
  localparam int GAIN_W     = 2;
  localparam int BUSY_BIT   = 7;
  localparam int SINGLE_BIT = 4;
  localparam int GAIN_LSB   = 0;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h80;
  // bits that are stored; busy is derived, reserved bits are dropped
  localparam logic [CFG_W-1:0] CFG_STORE_MASK = 8'h13;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              running_i,
  output logic              single_nxt_o,
  output logic [GAIN_W-1:0] gain_nxt_o,
  output logic              start_req_o,
  output logic [CFG_W-1:0]  cfg_rd_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] store_val;

  assign store_val = wdata_i & CFG_STORE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= CFG_RESET & CFG_STORE_MASK;
    else if (soft_rst_i) cfg_q <= CFG_RESET & CFG_STORE_MASK;
    else if (we_i)       cfg_q <= store_val;
  end

  // value in force this cycle, a write included
  assign single_nxt_o = we_i ? wdata_i[SINGLE_BIT] : cfg_q[SINGLE_BIT];
  assign gain_nxt_o   = we_i ? wdata_i[GAIN_LSB +: GAIN_W] : cfg_q[GAIN_LSB +: GAIN_W];
  assign start_req_o  = we_i && wdata_i[BUSY_BIT] && wdata_i[SINGLE_BIT];

  always_comb begin
    cfg_rd_o = cfg_q;
    cfg_rd_o[BUSY_BIT] = !cfg_q[SINGLE_BIT] || running_i;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              start_req_i,
  input  logic              single_nxt_i,
  input  logic [GAIN_W-1:0] gain_nxt_i,
  input  logic              done_i,
  output logic              running_o,
  output logic              start_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              capture_o
);
  seq_state_e        state_q;
  logic              start_q;
  logic [GAIN_W-1:0] gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
      gain_q  <= '0;
    end else if (soft_rst_i) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
      gain_q  <= '0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (!single_nxt_i || start_req_i) begin
            state_q <= SEQ_RUN;
            start_q <= 1'b1;
            gain_q  <= gain_nxt_i;
          end
        end
        SEQ_RUN: begin
          if (done_i) begin
            if (single_nxt_i) begin
              state_q <= SEQ_IDLE;
            end else begin
              start_q <= 1'b1;
              gain_q  <= gain_nxt_i;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign running_o = (state_q == SEQ_RUN);
  assign start_o   = start_q;
  assign gain_o    = gain_q;
  assign capture_o = done_i && (state_q == SEQ_RUN);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_mode_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                capture_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [RESULT_W-1:0] result_o
);
  localparam int EXT_W = RESULT_W - SAMPLE_W;
  logic [RESULT_W-1:0] result_q;
  logic [RESULT_W-1:0] sext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign sext = {{EXT_W{sample_i[SAMPLE_W-1]}}, sample_i};
    end else begin : g_noext
      assign sext = sample_i[RESULT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         result_q <= '0;
    else if (soft_rst_i) result_q <= '0;
    else if (capture_i)  result_q <= sext;
  end

  assign result_o = result_q;
endmodule

// File: rtl/adc_mode_ctrl.sv
module adc_mode_ctrl
  import adc_mode_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output logic [CFG_W-1:0]    cfg_o,
  output logic [RESULT_W-1:0] result_o,
  output logic                core_pwr_o,
  output logic                core_start_o,
  output logic [GAIN_W-1:0]   core_gain_o,
  input  logic                core_done_i,
  input  logic [SAMPLE_W-1:0] core_sample_i
);
  logic              running;
  logic              single_nxt;
  logic [GAIN_W-1:0] gain_nxt;
  logic              start_req;
  logic              capture;

  adc_cfg_reg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .we_i         (cfg_we_i),
    .wdata_i      (cfg_wdata_i),
    .running_i    (running),
    .single_nxt_o (single_nxt),
    .gain_nxt_o   (gain_nxt),
    .start_req_o  (start_req),
    .cfg_rd_o     (cfg_o)
  );

  adc_seq_fsm u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .start_req_i  (start_req),
    .single_nxt_i (single_nxt),
    .gain_nxt_i   (gain_nxt),
    .done_i       (core_done_i),
    .running_o    (running),
    .start_o      (core_start_o),
    .gain_o       (core_gain_o),
    .capture_o    (capture)
  );

  adc_result_reg u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .capture_i  (capture),
    .sample_i   (core_sample_i),
    .result_o   (result_o)
  );

  assign core_pwr_o = running;
endmodule

// File: rtl/adc_mode_ctrl_chk.sv
module adc_mode_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        soft_rst_i,
  input logic        cfg_we_i,
  input logic [7:0]  cfg_o,
  input logic [15:0] result_o,
  input logic        core_pwr_o,
  input logic        core_start_o,
  input logic [1:0]  core_gain_o,
  input logic        core_done_i
);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[6:5] == 2'b00) && (cfg_o[3:2] == 2'b00));

  a_r3_cont_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[4] |-> cfg_o[7]);

  a_r3_cont_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_done_i && core_pwr_o && !cfg_o[4] && !cfg_we_i && !soft_rst_i)
    |=> (core_start_o && core_pwr_o));

  a_r4_start_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> core_pwr_o);

  a_r5_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_pwr_o && !core_done_i && !soft_rst_i) |=> !core_start_o);

  a_r6_single_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_done_i && core_pwr_o && cfg_o[4] && !cfg_we_i && !soft_rst_i)
    |=> (!core_pwr_o && !cfg_o[7]));

  a_r8_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[15:12] == {4{result_o[11]}});

  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_done_i && !soft_rst_i) |=> $stable(result_o));

  a_r9_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (cfg_o == 8'h80 && result_o == 16'h0 && !core_pwr_o));

  a_r10_gain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_pwr_o && !core_done_i && !soft_rst_i) |=> $stable(core_gain_o));
endmodule

bind adc_mode_ctrl adc_mode_ctrl_chk u_chk (.*);

// File: tb/adc_mode_ctrl_bench.sv
module adc_mode_ctrl_bench;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  cfg;
  logic [15:0] result;
  logic        pwr, start;
  logic [1:0]  gain;
  logic        done = 1'b0;
  logic [11:0] sample = '0;
  logic [11:0] nxt_smp = '0;
  int          cnt = 0;
  int          n_start = 0;
  int          total = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  adc_mode_ctrl u_adc_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_o(cfg), .result_o(result),
    .core_pwr_o(pwr), .core_start_o(start), .core_gain_o(gain),
    .core_done_i(done), .core_sample_i(sample)
  );

  // core model: fixed latency from start to done
  always @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      cnt <= 0; done <= 1'b0;
    end else if (start) begin
      cnt <= LAT; done <= 1'b0;
    end else begin
      done <= (cnt == 1);
      if (cnt == 1) sample <= nxt_smp;
      if (cnt != 0) cnt <= cnt - 1;
    end
    if (start) n_start <= n_start + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_done();
    @(posedge clk iff done);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values before the first edge
    chk(cfg == 8'h80, "R1 cfg", cfg, 8'h80);
    chk(result == 16'h0, "R1 result", result, 0);
    @(negedge clk);
    chk(start && pwr, "R1 auto start", {start, pwr}, 3);

    // R8/R3: continuous sweep over the sample range
    for (int v = -2048; v <= 2047; v += 65) begin
      nxt_smp = v[11:0];
      wait_done();
      chk($signed(result) == v, "R8 sign-extended result", result, v);
      chk(start == 1'b1, "R3 immediate restart", start, 1);
      chk(cfg[7] == 1'b1, "R3 busy reads 1", cfg, 8'h80);
    end
    nxt_smp = 12'h7FF;
    wait_done();
    chk(result == 16'h07FF, "R8 max positive", result, 16'h07FF);

    // R3: busy bit write ignored; R2: reserved bits dropped
    @(negedge clk);
    wr(8'h01);
    chk(cfg == 8'h81, "R3 busy write ignored", cfg, 8'h81);
    chk(pwr == 1'b1, "R3 still powered", pwr, 1);
    wr(8'h6E);
    chk(cfg == 8'h82, "R2 reserved bits zero", cfg, 8'h82);
    // R10: gain change waits for next start
    chk(gain == 2'd0, "R10 gain held mid-conversion", gain, 0);
    wait_done();
    chk(start && gain == 2'd2, "R10 gain at next start", gain, 2);

    // R7: switch to single-shot mid-conversion
    @(negedge clk); @(negedge clk);
    wr(8'h10);
    chk(cfg == 8'h90, "R7 busy while finishing", cfg, 8'h90);
    chk(pwr == 1'b1, "R7 power kept", pwr, 1);
    nxt_smp = 12'd123;
    wait_done();
    chk(result == 16'd123, "R7 result stored", result, 123);
    chk(cfg == 8'h10 && !pwr, "R7 powered down", {cfg, 7'b0, pwr}, 16'h1000);
    s0 = n_start;
    repeat (20) @(negedge clk);
    chk(n_start == s0 && !pwr, "R6 no further start", n_start, s0);

    // R4: write without busy bit does nothing
    wr(8'h12);
    repeat (10) @(negedge clk);
    chk(n_start == s0 && !pwr, "R4 no start on bit7=0", n_start, s0);
    chk(cfg == 8'h12, "R4 cfg idle", cfg, 8'h12);
    // R4: arm one conversion
    wr(8'h93);
    chk(start && pwr, "R4 start pulse", {start, pwr}, 3);
    chk(cfg == 8'h93, "R4 busy reads 1", cfg, 8'h93);
    chk(gain == 2'd3, "R10 gain latched", gain, 3);
    // R5: re-arm while running
    @(negedge clk);
    s0 = n_start;
    wr(8'h91);
    nxt_smp = 12'hFFB;
    wait_done();
    chk(n_start == s0, "R5 no extra start", n_start, s0);
    chk(result == 16'hFFFB, "R6 single result", result, 16'hFFFB);
    chk(cfg == 8'h11 && !pwr, "R6 busy clear, power off", cfg, 8'h11);

    // R9: synchronous reset mid-conversion
    wr(8'h90);
    @(negedge clk); @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk(cfg == 8'h80, "R9 cfg restored", cfg, 8'h80);
    chk(result == 16'h0, "R9 result cleared", result, 0);
    chk(!pwr, "R9 conversion aborted", pwr, 0);
    @(negedge clk);
    chk(start == 1'b1, "R1 restart after soft reset", start, 1);
    repeat (4) @(negedge clk);
    chk(result == 16'h0, "R9 result stays zero", result, 0);
    nxt_smp = 12'h800;
    wait_done();
    chk(result == 16'hF800, "R8 most negative", result, 16'hF800);

    finish_run();
  end
endmodule